// File: doc/BRIEF.md
# Windowed PHY Control-Port Access Sequencer

This block turns one PHY register command (a device number, a 16-bit PHY register address and, for writes, a data word) into the ordered series of memory-mapped accesses that reach a PHY control-register port. It drives a simple request/acknowledge register bus. The PHY's internal space is only reachable through a window: the block first writes a page-select word to a fixed select offset, then accesses a word in the data aperture. Both accesses together make one low-level access.

On top of the window sits the PHY control port. It has three locations: a control location, an address location and a data location. Before any command, the block polls the control location until its busy bit clears. A read writes the address, starts the operation, polls busy a second time and then fetches the data location. A write writes the address, then the data, then starts the operation, and returns without a second poll. A poll limit, sampled when a command is accepted, ends a hung poll with an error flag.

The sequencer has the states SQ_IDLE, SQ_POLL_PRE, SQ_SET_ADDR, SQ_KICK_RD, SQ_POLL_POST, SQ_FETCH, SQ_PUT_DATA and SQ_KICK_WR. Its transitions:
- SQ_IDLE goes to SQ_POLL_PRE when a command is accepted.
- In either poll state, a busy result either repeats the poll or aborts to SQ_IDLE when the limit is reached. A clear result moves on: SQ_POLL_PRE goes to SQ_SET_ADDR, and SQ_POLL_POST goes to SQ_FETCH.
- SQ_SET_ADDR branches to SQ_KICK_RD for a read or to SQ_PUT_DATA for a write.
- SQ_KICK_RD goes to SQ_POLL_POST. SQ_PUT_DATA goes to SQ_KICK_WR.
- SQ_FETCH and SQ_KICK_WR return to SQ_IDLE with a done pulse.

The window engine has the states W_IDLE, W_SELECT and W_ACCESS. It goes W_IDLE to W_SELECT on a step request, W_SELECT to W_ACCESS on acknowledge, and W_ACCESS to W_IDLE on acknowledge.

Top module: `phy_indirect_master`

## Requirements
- R1: After reset, `bus_req` and `done` are 0 and `cmd_ready` is 1.
- R2: Every low-level access is a pair: first a write to bus offset 0x800 of the select word `(dev & 0x1F) << 7 | (reg >> 9) & 0x7F`, and then, with no other bus transfer in between, the aperture access.
- R3: The aperture offset is `(reg & 0x1FF) << 2`. The control port's control, address and data locations are PHY registers 0x80A0, 0x80A1 and 0x80A2. This gives select page 0x40 and aperture offsets 0x280, 0x284 and 0x288.
- R4: A read command issues, in order: busy polling, a write of the command address to the address location, a write of 0x1 to the control location, busy polling again, and a read of the data location.
- R5: A write command issues, in order: busy polling, a write of the address to the address location, a write of the command data to the data location, and a write of 0x3 to the control location. No poll follows.
- R6: A poll reads the control location and repeats while bit 0 of the returned word is 1.
- R7: If the number of busy results in one poll phase reaches the limit, the command ends with `done_err`=1 and `done_rdata`=0, and no further bus access is made. A limit of 0 acts as 1.
- R8: `done` is a one-cycle pulse per command. For a read, `done_rdata` carries the word returned by the data location; a write returns 0.
- R9: While `bus_req` is high without `bus_ack`, `bus_addr`, `bus_we` and `bus_wdata` hold their values.
- R10: `cmd_valid` while `cmd_ready` is 0 is ignored. It adds no bus transfer and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken this cycle if valid |
| cmd_write | input | 1 | 1 = PHY register write, 0 = read |
| cmd_dev | input | 5 | PHY device number for the window select |
| cmd_addr | input | 16 | PHY register address |
| cmd_wdata | input | 32 | Write data |
| poll_limit | input | 16 | Busy results allowed per poll phase |
| done | output | 1 | Command finished (one cycle) |
| done_err | output | 1 | Command aborted by poll limit |
| done_rdata | output | 32 | Read result |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | Transfer is a write |
| bus_addr | output | 16 | Byte offset on the register bus |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transfer completes this cycle |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
The bench targets the ordering differences between reads and writes. A design that appended a poll after a write, or fetched data before the second poll, would show up as an unexpected or missing bus transfer. Long busy runs check both polling repeats and the abort. A limit of zero checks the edge case: an off-by-one counter would make one extra control read or hang. Slow acknowledges check that a request holds steady while it waits. A select word built from the wrong address bits, or a stray command taken while busy, would break the expected transfer stream.

// File: rtl/phyacc_pkg.sv
package phyacc_pkg;

    // PHY control-port locations (register numbers inside the PHY space)
    localparam logic [15:0] CPORT_CTL  = 16'h80A0;
    localparam logic [15:0] CPORT_ADDR = 16'h80A1;
    localparam logic [15:0] CPORT_DATA = 16'h80A2;

    // control word bits
    localparam int unsigned CTL_BUSY_BIT = 0;
    localparam logic [31:0] CTL_GO_READ  = 32'h0000_0001;
    localparam logic [31:0] CTL_GO_WRITE = 32'h0000_0003;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_POLL_PRE,
        SQ_SET_ADDR,
        SQ_KICK_RD,
        SQ_POLL_POST,
        SQ_FETCH,
        SQ_PUT_DATA,
        SQ_KICK_WR
    } seq_state_t;

    typedef enum logic [1:0] {
        W_IDLE,
        W_SELECT,
        W_ACCESS
    } win_state_t;

endpackage

// File: rtl/phyacc_window_port.sv
module phyacc_window_port
    import phyacc_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned DEV_W   = 5,
    parameter int unsigned WORD_W  = 9,
    parameter logic [15:0] SEL_OFF = 16'h0800
) (
    input  logic              clk,
    input  logic              rst_n,
    // step request from the sequencer
    input  logic              ll_go,
    input  logic              ll_we,
    input  logic [DEV_W-1:0]  ll_dev,
    input  logic [ADDR_W-1:0] ll_reg,
    input  logic [DATA_W-1:0] ll_wdata,
    output logic              ll_done,
    output logic [DATA_W-1:0] ll_rdata,
    // register bus
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);

    localparam int unsigned PAGE_W = ADDR_W - WORD_W;
    localparam int unsigned SEL_PAD = DATA_W - DEV_W - PAGE_W;
    localparam int unsigned OFF_PAD = ADDR_W - WORD_W - 2;

    win_state_t        state, nxt;
    logic              we_q;
    logic [DEV_W-1:0]  dev_q;
    logic [ADDR_W-1:0] reg_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] sel_word;
    logic [ADDR_W-1:0] ap_off;

    assign sel_word = {{SEL_PAD{1'b0}}, dev_q, reg_q[ADDR_W-1 -: PAGE_W]};
    assign ap_off   = {{OFF_PAD{1'b0}}, reg_q[WORD_W-1:0], 2'b00};

    // state register and captured step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= W_IDLE;
            we_q     <= 1'b0;
            dev_q    <= '0;
            reg_q    <= '0;
            wdata_q  <= '0;
            ll_done  <= 1'b0;
            ll_rdata <= '0;
        end else begin
            state   <= nxt;
            ll_done <= (state == W_ACCESS) && bus_ack;
            if (state == W_ACCESS && bus_ack) begin
                ll_rdata <= bus_rdata;
            end
            if (state == W_IDLE && ll_go) begin
                we_q    <= ll_we;
                dev_q   <= ll_dev;
                reg_q   <= ll_reg;
                wdata_q <= ll_wdata;
            end
        end
    end

    // next state and bus outputs
    always_comb begin
        nxt       = state;
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (state)
            W_IDLE: begin
                if (ll_go) nxt = W_SELECT;
            end
            W_SELECT: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = ADDR_W'(SEL_OFF);
                bus_wdata = sel_word;
                if (bus_ack) nxt = W_ACCESS;
            end
            W_ACCESS: begin
                bus_req   = 1'b1;
                bus_we    = we_q;
                bus_addr  = ap_off;
                bus_wdata = we_q ? wdata_q : '0;
                if (bus_ack) nxt = W_IDLE;
            end
            default: nxt = W_IDLE;
        endcase
    end

    // R9: request fields hold while waiting for acknowledge
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R2: a completed select write is followed at once by the aperture access
    p_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && bus_we && bus_addr == ADDR_W'(SEL_OFF)) |=> (bus_req && bus_addr != ADDR_W'(SEL_OFF)));

    // R2: the sequencer only asks for a step when the engine is free
    p_go_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ll_go |-> (state == W_IDLE));

endmodule

// File: rtl/phyacc_sequencer.sv
module phyacc_sequencer
    import phyacc_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEV_W  = 5,
    parameter int unsigned POLL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [DEV_W-1:0]  cmd_dev,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [POLL_W-1:0] poll_limit,
    output logic              done,
    output logic              done_err,
    output logic [DATA_W-1:0] done_rdata,
    // step interface to the window engine
    output logic              ll_go,
    output logic              ll_we,
    output logic [DEV_W-1:0]  ll_dev,
    output logic [ADDR_W-1:0] ll_reg,
    output logic [DATA_W-1:0] ll_wdata,
    input  logic              ll_done,
    input  logic [DATA_W-1:0] ll_rdata
);

    seq_state_t        state, nxt;
    logic              issued;
    logic              write_q;
    logic [DEV_W-1:0]  dev_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [POLL_W-1:0] lim_q;
    logic [POLL_W-1:0] cnt, cnt_nxt;
    logic              done_nxt, err_nxt;
    logic [DATA_W-1:0] rdata_nxt;
    logic              busy_seen;
    logic              limit_hit;
    logic              accept;

    assign accept    = (state == SQ_IDLE) && cmd_valid;
    assign cmd_ready = (state == SQ_IDLE);
    assign busy_seen = ll_rdata[CTL_BUSY_BIT];
    assign limit_hit = ({1'b0, cnt} + 1'b1) >= {1'b0, lim_q};
    assign ll_go     = (state != SQ_IDLE) && !issued;
    assign ll_dev    = dev_q;

    // state register and command capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            issued     <= 1'b0;
            cnt        <= '0;
            write_q    <= 1'b0;
            dev_q      <= '0;
            addr_q     <= '0;
            wdata_q    <= '0;
            lim_q      <= POLL_W'(1);
            done       <= 1'b0;
            done_err   <= 1'b0;
            done_rdata <= '0;
        end else begin
            state      <= nxt;
            cnt        <= cnt_nxt;
            done       <= done_nxt;
            done_err   <= err_nxt;
            done_rdata <= rdata_nxt;
            if (ll_go) begin
                issued <= 1'b1;
            end else if (ll_done) begin
                issued <= 1'b0;
            end
            if (accept) begin
                write_q <= cmd_write;
                dev_q   <= cmd_dev;
                addr_q  <= cmd_addr;
                wdata_q <= cmd_wdata;
                lim_q   <= (poll_limit == '0) ? POLL_W'(1) : poll_limit;
            end
        end
    end

    // next state, step description and result
    always_comb begin
        nxt       = state;
        cnt_nxt   = cnt;
        done_nxt  = 1'b0;
        err_nxt   = 1'b0;
        rdata_nxt = '0;
        ll_we     = 1'b0;
        ll_reg    = ADDR_W'(CPORT_CTL);
        ll_wdata  = '0;
        unique case (state)
            SQ_IDLE: begin
                if (cmd_valid) begin
                    nxt     = SQ_POLL_PRE;
                    cnt_nxt = '0;
                end
            end
            SQ_POLL_PRE, SQ_POLL_POST: begin
                ll_reg = ADDR_W'(CPORT_CTL);
                if (ll_done) begin
                    if (busy_seen) begin
                        if (limit_hit) begin
                            nxt      = SQ_IDLE;
                            done_nxt = 1'b1;
                            err_nxt  = 1'b1;
                            cnt_nxt  = '0;
                        end else begin
                            cnt_nxt = cnt + 1'b1;
                        end
                    end else begin
                        cnt_nxt = '0;
                        nxt     = (state == SQ_POLL_PRE) ? SQ_SET_ADDR : SQ_FETCH;
                    end
                end
            end
            SQ_SET_ADDR: begin
                ll_we    = 1'b1;
                ll_reg   = ADDR_W'(CPORT_ADDR);
                ll_wdata = DATA_W'(addr_q);
                if (ll_done) nxt = write_q ? SQ_PUT_DATA : SQ_KICK_RD;
            end
            SQ_KICK_RD: begin
                ll_we    = 1'b1;
                ll_reg   = ADDR_W'(CPORT_CTL);
                ll_wdata = DATA_W'(CTL_GO_READ);
                if (ll_done) nxt = SQ_POLL_POST;
            end
            SQ_FETCH: begin
                ll_reg = ADDR_W'(CPORT_DATA);
                if (ll_done) begin
                    nxt       = SQ_IDLE;
                    done_nxt  = 1'b1;
                    rdata_nxt = ll_rdata;
                end
            end
            SQ_PUT_DATA: begin
                ll_we    = 1'b1;
                ll_reg   = ADDR_W'(CPORT_DATA);
                ll_wdata = wdata_q;
                if (ll_done) nxt = SQ_KICK_WR;
            end
            SQ_KICK_WR: begin
                ll_we    = 1'b1;
                ll_reg   = ADDR_W'(CPORT_CTL);
                ll_wdata = DATA_W'(CTL_GO_WRITE);
                if (ll_done) begin
                    nxt      = SQ_IDLE;
                    done_nxt = 1'b1;
                end
            end
            default: nxt = SQ_IDLE;
        endcase
    end

    // R7: the busy count of a poll phase stays below the limit
    p_poll_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SQ_IDLE) |-> (cnt < lim_q));

    // R7: an aborted command reports zero data
    p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_err) |-> (done_rdata == '0));

    // R8: done lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: a command offered while busy does not disturb the captured one
    p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SQ_IDLE && cmd_valid) |=> ($stable(addr_q) && $stable(write_q) && $stable(wdata_q)));

endmodule

// File: rtl/phy_indirect_master.sv
module phy_indirect_master
    import phyacc_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned DEV_W   = 5,
    parameter int unsigned WORD_W  = 9,
    parameter int unsigned POLL_W  = 16,
    parameter logic [15:0] SEL_OFF = 16'h0800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [DEV_W-1:0]  cmd_dev,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [POLL_W-1:0] poll_limit,
    output logic              done,
    output logic              done_err,
    output logic [DATA_W-1:0] done_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);

    logic              ll_go, ll_we, ll_done;
    logic [DEV_W-1:0]  ll_dev;
    logic [ADDR_W-1:0] ll_reg;
    logic [DATA_W-1:0] ll_wdata, ll_rdata;

    phyacc_sequencer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_W(DEV_W), .POLL_W(POLL_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_dev(cmd_dev), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .poll_limit(poll_limit),
        .done(done), .done_err(done_err), .done_rdata(done_rdata),
        .ll_go(ll_go), .ll_we(ll_we), .ll_dev(ll_dev), .ll_reg(ll_reg),
        .ll_wdata(ll_wdata), .ll_done(ll_done), .ll_rdata(ll_rdata)
    );

    phyacc_window_port #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_W(DEV_W), .WORD_W(WORD_W), .SEL_OFF(SEL_OFF)
    ) u_win (
        .clk(clk), .rst_n(rst_n),
        .ll_go(ll_go), .ll_we(ll_we), .ll_dev(ll_dev), .ll_reg(ll_reg),
        .ll_wdata(ll_wdata), .ll_done(ll_done), .ll_rdata(ll_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    // R1: nothing is requested while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !bus_req);

endmodule

// File: tb/phy_indirect_master_test.sv
module phy_indirect_master_test;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        cmd_valid, cmd_write;
    logic        cmd_ready;
    logic [4:0]  cmd_dev;
    logic [15:0] cmd_addr;
    logic [31:0] cmd_wdata;
    logic [15:0] poll_limit;
    logic        done, done_err;
    logic [31:0] done_rdata;
    logic        bus_req, bus_we, bus_ack;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;

    phy_indirect_master uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_dev(cmd_dev), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .poll_limit(poll_limit),
        .done(done), .done_err(done_err), .done_rdata(done_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    typedef struct {
        bit          we;
        logic [15:0] addr;
        logic [31:0] wdata;
        string       tag;
    } bus_item_t;

    typedef struct {
        bit          err;
        logic [31:0] rdata;
        string       tag;
    } done_item_t;

    bus_item_t  bus_q[$];
    done_item_t done_q[$];

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- slave model + monitor ----------------
    logic [31:0] sel_reg = '0;
    int          busy_left = 0;
    int          busy_after = 0;
    int          gap = 0;
    int          wait_cnt = 0;
    int          load_tag = 0, load_seen = 0, load_val = 0;
    logic [15:0] cr_addr = '0;
    logic [31:0] cr_data = '0;
    bit          hold_v = 0;
    logic [15:0] hold_addr;
    logic        hold_we;
    logic [31:0] hold_wd;

    initial begin
        bus_ack   = 1'b0;
        bus_rdata = '0;
    end

    task automatic serve_xfer();
        bus_item_t   e;
        logic [15:0] regn;
        if (bus_q.size() == 0) begin
            check(0, "R10 unexpected transfer", {16'h0, bus_addr}, 32'h0);
        end else begin
            e = bus_q.pop_front();
            check(bus_we == e.we && bus_addr == e.addr && (!e.we || bus_wdata == e.wdata),
                  e.tag, {bus_we, bus_addr[14:0], bus_wdata[15:0]}, {e.we, e.addr[14:0], e.wdata[15:0]});
        end
        bus_rdata = '0;
        if (bus_addr == 16'h0800 && bus_we) begin
            sel_reg = bus_wdata;
        end else begin
            regn = {sel_reg[6:0], bus_addr[10:2]};
            case (regn)
                16'h80A0: begin
                    if (bus_we) begin
                        if (bus_wdata[0]) busy_left = busy_after;
                        if (bus_wdata[0] && !bus_wdata[1]) cr_data = {16'hA5A5, cr_addr};
                    end else begin
                        bus_rdata = (busy_left > 0) ? 32'h1 : 32'h0;
                        if (busy_left > 0) busy_left--;
                    end
                end
                16'h80A1: if (bus_we) cr_addr = bus_wdata[15:0];
                16'h80A2: begin
                    if (bus_we) cr_data = bus_wdata;
                    else bus_rdata = cr_data;
                end
                default: ;
            endcase
        end
    endtask

    always @(negedge clk) begin
        done_item_t d;
        if (load_seen != load_tag) begin
            busy_left = load_val;
            load_seen = load_tag;
        end
        if (!rst_n) begin
            bus_ack  = 1'b0;
            wait_cnt = 0;
            hold_v   = 0;
        end else begin
            if (hold_v) begin
                check(bus_req && bus_addr == hold_addr && bus_we == hold_we && bus_wdata == hold_wd,
                      "R9 request changed while waiting", {bus_req, bus_addr[14:0], bus_wdata[15:0]},
                      {1'b1, hold_addr[14:0], hold_wd[15:0]});
            end
            bus_ack = 1'b0;
            hold_v  = 0;
            if (bus_req) begin
                if (wait_cnt < gap) begin
                    wait_cnt++;
                    hold_v    = 1;
                    hold_addr = bus_addr;
                    hold_we   = bus_we;
                    hold_wd   = bus_wdata;
                end else begin
                    wait_cnt = 0;
                    bus_ack  = 1'b1;
                    serve_xfer();
                end
            end
            if (done) begin
                if (done_q.size() == 0) begin
                    check(0, "R10 R8 unexpected done", 32'h1, 32'h0);
                end else begin
                    d = done_q.pop_front();
                    check(done_err == d.err && done_rdata == d.rdata, d.tag,
                          {done_err, done_rdata[30:0]}, {d.err, d.rdata[30:0]});
                end
            end
        end
    end

    // ---------------- driver ----------------
    task automatic push_pair(logic [4:0] dev, logic [15:0] regn, bit we, logic [31:0] data, string tag);
        bus_item_t s, a;
        s.we = 1; s.addr = 16'h0800;
        s.wdata = {20'h0, dev, regn[15:9]};
        s.tag = "R2 select word";
        a.we = we; a.addr = {5'h0, regn[8:0], 2'b00};
        a.wdata = data; a.tag = tag;
        bus_q.push_back(s);
        bus_q.push_back(a);
    endtask

    task automatic set_busy(int b);
        load_val = b;
        load_tag++;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send(bit wr, logic [4:0] dev, logic [15:0] addr, logic [31:0] data, logic [15:0] lim);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_write  = wr;
        cmd_dev    = dev;
        cmd_addr   = addr;
        cmd_wdata  = data;
        poll_limit = lim;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    // expected stream for a read with pre/post busy counts
    task automatic expect_read(logic [4:0] dev, logic [15:0] addr, int pre, int post, int lim);
        done_item_t d;
        int eff = (lim == 0) ? 1 : lim;
        if (pre >= eff) begin
            for (int i = 0; i < eff; i++) push_pair(dev, 16'h80A0, 0, 0, "R7 R6 poll before abort");
            d.err = 1; d.rdata = 0; d.tag = "R7 abort result";
            done_q.push_back(d);
            return;
        end
        for (int i = 0; i <= pre; i++) push_pair(dev, 16'h80A0, 0, 0, "R6 R3 pre poll at 0x280");
        push_pair(dev, 16'h80A1, 1, {16'h0, addr}, "R4 R3 address write at 0x284");
        push_pair(dev, 16'h80A0, 1, 32'h1, "R4 start read 0x1");
        for (int i = 0; i <= post; i++) push_pair(dev, 16'h80A0, 0, 0, "R4 R6 post poll");
        push_pair(dev, 16'h80A2, 0, 0, "R4 R3 data fetch at 0x288");
        d.err = 0; d.rdata = {16'hA5A5, addr}; d.tag = "R8 read data";
        done_q.push_back(d);
    endtask

    task automatic expect_write(logic [4:0] dev, logic [15:0] addr, logic [31:0] data, int pre);
        done_item_t d;
        for (int i = 0; i <= pre; i++) push_pair(dev, 16'h80A0, 0, 0, "R5 R6 pre poll");
        push_pair(dev, 16'h80A1, 1, {16'h0, addr}, "R5 address write");
        push_pair(dev, 16'h80A2, 1, data, "R5 data write");
        push_pair(dev, 16'h80A0, 1, 32'h3, "R5 start write 0x3");
        d.err = 0; d.rdata = 0; d.tag = "R8 write result";
        done_q.push_back(d);
    endtask

    task automatic drain_check(string tag);
        check(bus_q.size() == 0 && done_q.size() == 0, tag, bus_q.size(), 0);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        report();
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 0; cmd_write = 0; cmd_dev = 0;
        cmd_addr = 0; cmd_wdata = 0; poll_limit = 16'd8;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(bus_req == 0, "R1 bus_req after reset", bus_req, 0);
        check(done == 0, "R1 done after reset", done, 0);
        check(cmd_ready == 1, "R1 cmd_ready after reset", cmd_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // plain read, no busy, immediate ack
        gap = 0; busy_after = 0; set_busy(0);
        expect_read(5'd3, 16'h2002, 0, 0, 8);
        send(0, 5'd3, 16'h2002, 0, 16'd8); wait_done();
        drain_check("R4 read stream complete");

        // write with busy polling and slow ack
        gap = 2; busy_after = 1; set_busy(2);
        expect_write(5'd5, 16'h2105, 32'h0000_1234, 2);
        send(1, 5'd5, 16'h2105, 32'h0000_1234, 16'd8); wait_done();
        drain_check("R5 write stream has no trailing poll");

        // read following a write: slave still busy once; post busy once
        gap = 1; busy_after = 1;
        expect_read(5'd31, 16'hFFFF, 1, 1, 8);
        send(0, 5'd31, 16'hFFFF, 0, 16'd8); wait_done();
        drain_check("R4 R6 read with polling complete");

        // abort: limit 3, busy 10
        gap = 0; busy_after = 0; set_busy(10);
        expect_read(5'd7, 16'h4000, 10, 0, 3);
        send(0, 5'd7, 16'h4000, 0, 16'd3); wait_done();
        repeat (5) @(negedge clk);
        check(bus_req == 0, "R7 no access after abort", bus_req, 0);
        drain_check("R7 abort stream");

        // limit 0 behaves as 1
        set_busy(1);
        expect_read(5'd1, 16'h0010, 1, 0, 0);
        send(0, 5'd1, 16'h0010, 0, 16'd0); wait_done();
        drain_check("R7 zero limit acts as one");

        // ignored command while busy
        gap = 3; set_busy(0);
        expect_read(5'd2, 16'h0123, 0, 0, 8);
        send(0, 5'd2, 16'h0123, 0, 16'd8);
        repeat (3) @(negedge clk);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 16'hBEEF; cmd_wdata = 32'h5555_5555;
        repeat (2) @(negedge clk);
        cmd_valid = 1'b0;
        wait_done();
        repeat (10) @(negedge clk);
        check(bus_req == 0, "R10 idle after ignored command", bus_req, 0);
        drain_check("R10 no extra transfer or done");

        report();
    end

endmodule